// File: doc/BRIEF.md
# Per-Trace Speculative Register Store

This block holds register state for a processor that runs several speculative traces of one decision tree at the same time. Each trace owns a private working register file, and every operation of that trace reads and writes only that file. One shadow register file, common to all traces, holds the architectural state as of the last trace that ended on a confirmed prediction.

Write requests carry a trace id and update that trace's working file. The read port returns the value of one register of one trace's working file. When a trace's closing decision confirms its prediction, a commit copies that trace's whole working set into the shadow file in one cycle. In the same cycle, every other trace that the caller marks as a peer in the same decision tree is flushed: its working file is reloaded with the newly committed state. When a trace is mispredicted, a discard reloads its working file from the shadow file. The caller chooses which trace commits and which traces are peers.

Top module: `spec_trace_regs`

## Requirements
- R1: Reset (synchronous, active high) sets every register of every working file and of the shadow file to zero.
- R2: A write with `wr_en` high updates register `wr_addr` of trace `wr_trace` only, at the next clock edge; the working files of the other traces keep their values.
- R3: `rd_data` is a combinational view of register `rd_addr` in the working file of trace `rd_trace`; a write becomes visible on it in the cycle after its clock edge, not before.
- R4: With `commit_en` high, the working set of trace `commit_trace` is copied into the shadow file at the next edge; without `commit_en` the shadow file does not change.
- R5: A write to the committing trace in the commit cycle is part of the committed state and is also kept in that trace's working file.
- R6: In a commit cycle, every trace whose bit is set in `peer_mask` (bit i for trace i), other than the committing trace, is reloaded with the committed state at the same edge; a write to such a trace in that cycle is dropped.
- R7: A commit leaves the working file of any trace whose `peer_mask` bit is clear unchanged, apart from that trace's own write in the same cycle.
- R8: With `discard_en` high and `commit_en` low, trace `discard_trace` has its working file reloaded from the shadow file at the next edge; a write to that trace in the same cycle is dropped.
- R9: `discard_en` has no effect in a cycle where `commit_en` is high; writes to that trace then proceed as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request valid |
| wr_trace | input | 2 | Trace id of the write |
| wr_addr | input | 4 | Register index of the write |
| wr_data | input | 32 | Write value |
| rd_trace | input | 2 | Trace id of the read |
| rd_addr | input | 4 | Register index of the read |
| rd_data | output | 32 | Read value from the selected working file |
| commit_en | input | 1 | Commit the working set of `commit_trace` |
| commit_trace | input | 2 | Trace being committed |
| peer_mask | input | 4 | Traces in the same decision tree, flushed on commit |
| discard_en | input | 1 | Discard the working set of `discard_trace` |
| discard_trace | input | 2 | Trace being discarded |

## Verification
The assertions assume the caller never asks for a commit and a discard of conflicting intent except as R9 defines, and that `peer_mask` may include the committing trace, whose bit is then ignored. They also take the trace id inputs as always in range, which holds because the trace count is a power of two. The stimulus drives every control input from a table at the falling edge, including commit and discard cycles with coincident writes to committing, flushed, discarded and untouched traces, so every priority rule is reached while the inputs stay inside those assumptions. Since the shadow file has no read port, its contents are observed by discarding a trace and reading it back.

// File: rtl/spec_regs_pkg.sv
package spec_regs_pkg;

    localparam int TRACES = 4;
    localparam int REGS   = 16;
    localparam int DW     = 32;
    localparam int TID_W  = $clog2(TRACES);
    localparam int RA_W   = $clog2(REGS);

    typedef logic [DW-1:0]            word_t;
    typedef logic [TID_W-1:0]         tid_t;
    typedef logic [RA_W-1:0]          raddr_t;
    typedef logic [REGS-1:0][DW-1:0]  regset_t;

    typedef struct packed {
        logic   en;
        tid_t   tid;
        raddr_t addr;
        word_t  data;
    } wr_req_t;

    function automatic regset_t merge_write(regset_t base, logic en,
                                            raddr_t addr, word_t data);
        regset_t r;
        r = base;
        if (en) r[addr] = data;
        return r;
    endfunction

endpackage

// File: rtl/shadow_file.sv
module shadow_file
    import spec_regs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  regset_t load_src,
    output regset_t regs
);
    always_ff @(posedge clk) begin
        if (rst)       regs <= '0;
        else if (load) regs <= load_src;
    end
endmodule

// File: rtl/trace_work_file.sv
module trace_work_file
    import spec_regs_pkg::*;
#(
    parameter int MY_ID = 0
)(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    input  logic    reload,
    input  regset_t reload_src,
    output regset_t regs
);
    localparam tid_t ID = tid_t'(MY_ID);

    logic own_write;
    assign own_write = wr.en && (wr.tid == ID);

    always_ff @(posedge clk) begin
        if (rst)            regs <= '0;
        else if (reload)    regs <= reload_src;
        else if (own_write) regs[wr.addr] <= wr.data;
    end
endmodule

// File: rtl/spec_trace_regs.sv
module spec_trace_regs
    import spec_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_trace,
    input  logic [3:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [1:0]    rd_trace,
    input  logic [3:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic          commit_en,
    input  logic [1:0]    commit_trace,
    input  logic [3:0]    peer_mask,
    input  logic          discard_en,
    input  logic [1:0]    discard_trace
);
    wr_req_t           wr;
    regset_t           work   [TRACES];
    regset_t           shadow;
    regset_t           commit_set;
    logic [TRACES-1:0] reload;
    regset_t           reload_src;

    assign wr = '{en: wr_en, tid: tid_t'(wr_trace), addr: raddr_t'(wr_addr),
                  data: word_t'(wr_data)};

    // committed image: committing trace's set with its same-cycle write folded in
    assign commit_set = merge_write(work[commit_trace],
                                    wr_en && (wr_trace == commit_trace),
                                    raddr_t'(wr_addr), word_t'(wr_data));

    assign reload_src = commit_en ? commit_set : shadow;

    shadow_file u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (commit_en),
        .load_src (commit_set),
        .regs     (shadow)
    );

    for (genvar t = 0; t < TRACES; t++) begin : g_trace
        localparam tid_t T_ID = tid_t'(t);

        assign reload[t] = commit_en
                         ? (peer_mask[t] && (commit_trace != T_ID))
                         : (discard_en && (discard_trace == T_ID));

        trace_work_file #(.MY_ID(t)) u_work (
            .clk        (clk),
            .rst        (rst),
            .wr         (wr),
            .reload     (reload[t]),
            .reload_src (reload_src),
            .regs       (work[t])
        );

        AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (rst)
            past_ok && !commit_en && !(discard_en && discard_trace == T_ID)
            && !(wr_en && wr_trace == T_ID) |=> $stable(work[t])); // R2

        AST_DISCARD_RESTORE: assert property (@(posedge clk) disable iff (rst)
            past_ok && discard_en && !commit_en && discard_trace == T_ID
            |=> work[t] == $past(shadow)); // R8

        AST_FLUSH_PEER: assert property (@(posedge clk) disable iff (rst)
            past_ok && commit_en && peer_mask[t] && commit_trace != T_ID
            |=> work[t] == shadow); // R6

        AST_NONPEER_KEEP: assert property (@(posedge clk) disable iff (rst)
            past_ok && commit_en && !peer_mask[t] && commit_trace != T_ID
            && !(wr_en && wr_trace == T_ID) |=> $stable(work[t])); // R7
    end

    assign rd_data = work[rd_trace][rd_addr];

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        past_ok && $past(rst) |-> shadow == '0 && rd_data == '0); // R1

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        past_ok && !commit_en |=> $stable(shadow)); // R4

    AST_COMMIT_MATCH: assert property (@(posedge clk) disable iff (rst)
        past_ok && commit_en |=> shadow == work[$past(commit_trace)]); // R5

endmodule

// File: tb/spec_trace_regs_tb.sv
module spec_trace_regs_tb_top;
    import spec_regs_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_trace;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_trace;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        commit_en;
    logic [1:0]  commit_trace;
    logic [3:0]  peer_mask;
    logic        discard_en;
    logic [1:0]  discard_trace;

    always #2 clk = ~clk;

    spec_trace_regs dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_trace(wr_trace), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_trace(rd_trace), .rd_addr(rd_addr), .rd_data(rd_data),
        .commit_en(commit_en), .commit_trace(commit_trace), .peer_mask(peer_mask),
        .discard_en(discard_en), .discard_trace(discard_trace)
    );

    typedef struct packed {
        logic        we;  logic [1:0] wt; logic [3:0] wa; logic [31:0] wd;
        logic        ce;  logic [1:0] ct; logic [3:0] pm;
        logic        de;  logic [1:0] dt;
        logic [1:0]  rt;  logic [3:0] ra; logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1,0,3,32'h11, 0,0,4'h0, 0,0, 0,3,32'h11, 2},  // R2 write T0
        '{1,1,3,32'h22, 0,0,4'h0, 0,0, 0,3,32'h11, 2},  // R2 T0 untouched
        '{0,0,0,32'h0,  0,0,4'h0, 0,0, 1,3,32'h22, 3},  // R3 read T1
        '{1,2,5,32'h33, 0,0,4'h0, 0,0, 3,5,32'h0,  2},  // R2 T3 untouched
        '{1,0,4,32'h44, 1,0,4'h3, 0,0, 1,3,32'h11, 6},  // R6 flush T1
        '{0,0,0,32'h0,  0,0,4'h0, 0,0, 1,4,32'h44, 5},  // R5 merged write
        '{0,0,0,32'h0,  0,0,4'h0, 0,0, 2,5,32'h33, 7},  // R7 non-peer kept
        '{0,0,0,32'h0,  0,0,4'h0, 1,2, 2,5,32'h0,  8},  // R8 discard T2
        '{0,0,0,32'h0,  0,0,4'h0, 0,0, 2,3,32'h11, 8},  // R8 shadow value
        '{1,3,7,32'h55, 0,0,4'h0, 1,3, 3,7,32'h0,  8},  // R8 write dropped
        '{1,1,0,32'h66, 1,3,4'h8, 1,1, 1,0,32'h66, 9},  // R9 discard ignored
        '{1,3,9,32'h77, 1,3,4'h0, 0,0, 3,9,32'h77, 5},  // R5 kept in working
        '{0,0,0,32'h0,  0,0,4'h0, 1,0, 0,9,32'h77, 4},  // R4 commit in shadow
        '{0,0,0,32'h0,  0,0,4'h0, 0,0, 0,4,32'h44, 4},  // R4 earlier commit
        '{1,2,1,32'h99, 1,0,4'h6, 0,0, 2,1,32'h0,  6},  // R6 peer write dropped
        '{0,0,0,32'h0,  0,0,4'h0, 0,0, 2,9,32'h77, 6}   // R6 committed image
    };

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_trace = 0; wr_addr = 0; wr_data = 0;
        commit_en = 0; commit_trace = 0; peer_mask = 0;
        discard_en = 0; discard_trace = 0;
    endtask

    initial begin
        logic all_zero;
        idle();
        rd_trace = 0; rd_addr = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state across every trace and register
        all_zero = 1'b1;
        for (int t = 0; t < TRACES; t++) begin
            for (int r = 0; r < REGS; r++) begin
                rd_trace = 2'(t); rd_addr = 4'(r);
                #0.1;
                if (rd_data !== 32'h0) all_zero = 1'b0;
            end
        end
        check("R1 reset clear", {31'h0, all_zero}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i].we; wr_trace = VEC[i].wt; wr_addr = VEC[i].wa; wr_data = VEC[i].wd;
            commit_en = VEC[i].ce; commit_trace = VEC[i].ct; peer_mask = VEC[i].pm;
            discard_en = VEC[i].de; discard_trace = VEC[i].dt;
            rd_trace = VEC[i].rt; rd_addr = VEC[i].ra;
            @(posedge clk);
            #1;
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rd_data, VEC[i].exp);
            idle();
        end

        // R3 write not visible before its edge, visible after
        @(negedge clk);
        wr_en = 1; wr_trace = 1; wr_addr = 2; wr_data = 32'hAB;
        rd_trace = 1; rd_addr = 2;
        #1 check("R3 before edge", rd_data, 32'h0);
        @(posedge clk);
        #1 check("R3 after edge", rd_data, 32'hAB);
        idle();

        // R1 reset in mid-run clears working and shadow
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 check("R1 working cleared", rd_data, 32'h0);
        @(negedge clk) begin rst = 1'b0; discard_en = 1; discard_trace = 2; rd_trace = 2; rd_addr = 9; end
        @(posedge clk);
        #1 check("R1 shadow cleared", rd_data, 32'h0);
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule